// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the external-bus engine of a CPU. The core gives it one access at a time. Each access carries an address, a direction (read or write), a space (memory or I/O), write data and a chip-select index. The block plays that access out on a shared address/data bus in four states, T1 to T4. It can stretch the cycle with wait states when the addressed device holds its ready line low. When the cycle ends, it hands the captured read data back to the core together with a one-cycle done pulse.

The block runs on a clock at twice the system clock, so every T-state spans two clocks (phase 0, then phase 1). This lets the address latch enable fall in the middle of T1. The ready input passes through one register before it is used. The decision to insert a wait is taken from the value of ready_i that was present one system clock before T3 begins. Once inserted, wait states repeat in whole system clocks until ready is seen high.

Top module: `mux_bus_master`

## Requirements
- R1: After reset the block is idle. busy_o, done_o, ale_o and ad_oe_o are 0. rd_n_o, wr_n_o, mreq_n_o and iorq_n_o are 1, and every cs_n_o bit is 1.
- R2: A request (req_i high) is accepted only while busy_o is 0. A request raised while a cycle is in progress is ignored and never starts a cycle.
- R3: Counting clocks after the accepting edge as c = 1, 2, ..., T1 is c = 1..2. During T1, ad_o carries the address and ad_oe_o is 1. ale_o is 1 only in c = 1. cs_n_o bit req_cs_i is 0, and only that bit, from c = 1 through the end of T4.
- R4: From T2 through T4, a write drives the write data with ad_oe_o = 1, and a read keeps ad_oe_o = 0.
- R5: A read holds rd_n_o low from the start of T2 (c = 3) until T4 begins. A write does the same with wr_n_o. The two strobes are never low together.
- R6: From T2 through the end of T4, mreq_n_o is low when req_io_i = 0 and iorq_n_o is low when req_io_i = 1. The two are never low together.
- R7: With ready_i held high, a cycle is busy for exactly 8 clocks. T2 is c = 3..4, T3 is c = 5..6 and T4 is c = 7..8, and done_o is 1 in c = 9.
- R8: If ready_i is 0 at the clock edge that ends c = 3, wait states are inserted after T3, each 2 clocks long. Wait w (w >= 1) ends at the edge after c = 6+2w. It is the last wait when ready_i was 1 at the edge ending c = 5+2w. With w waits, the cycle is busy for 8+2w clocks.
- R9: ready_i going low only after the edge that ends c = 3 inserts no wait state.
- R10: For a read, ad_i is captured at the edge that enters T4 and appears on rdata_o while done_o is 1. done_o is high for a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request from the core |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr_i | input | BW | Access address |
| req_wdata_i | input | BW | Write data |
| req_cs_i | input | CSW | Chip-select index |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | BW | Captured read data |
| ad_o | output | BW | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| ad_i | input | BW | Shared bus input value |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| mreq_n_o | output | 1 | Memory space strobe, active low |
| iorq_n_o | output | 1 | I/O space strobe, active low |
| cs_n_o | output | NCS | Chip selects, active low |
| ready_i | input | 1 | Device ready; low requests wait states |

## Verification
The hardest cases are the wait-state boundaries. These are the exact clock at which ready_i must already be low to stretch the cycle, and the clock at which a rising ready_i ends the waits. The stimulus drives ready_i low over a window of clocks counted from the accepting edge, with every edge placed deliberately. One window starts before the request and ends at chosen clocks, giving two and four waits. Another window opens only inside T3, where the drop must be ignored. In every case the bench derives the expected cycle length and strobe timing from the window.

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
  parameter int BW  = 16,
  parameter int NCS = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  logic           req_write_i,
  input  logic           req_io_i,
  input  logic [BW-1:0]  req_addr_i,
  input  logic [BW-1:0]  req_wdata_i,
  input  logic [CSW-1:0] req_cs_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [BW-1:0]  rdata_o,
  output logic [BW-1:0]  ad_o,
  output logic           ad_oe_o,
  input  logic [BW-1:0]  ad_i,
  output logic           ale_o,
  output logic           rd_n_o,
  output logic           wr_n_o,
  output logic           mreq_n_o,
  output logic           iorq_n_o,
  output logic [NCS-1:0] cs_n_o,
  input  logic           ready_i
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} tstate_t;

  tstate_t        st;
  logic           ph;
  logic           is_wr, is_io;
  logic [BW-1:0]  addr_q, wdata_q, rdata_q;
  logic [CSW-1:0] cs_q;
  logic           rdy_q, wait_pend, done_q;

  logic active, strobe_win, data_win;
  assign active     = (st != S_IDLE);
  assign strobe_win = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign data_win   = strobe_win || (st == S_T4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= 1'b0;
      is_wr     <= 1'b0;
      is_io     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      cs_q      <= '0;
      rdy_q     <= 1'b1;
      wait_pend <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      rdy_q  <= ready_i;
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        ph <= 1'b0;
        if (req_i) begin
          st      <= S_T1;
          is_wr   <= req_write_i;
          is_io   <= req_io_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          cs_q    <= req_cs_i;
        end
      end else begin
        ph <= ~ph;
        if (ph) begin
          unique case (st)
            S_T1: st <= S_T2;
            S_T2: begin
              st        <= S_T3;
              wait_pend <= ~rdy_q;
            end
            S_T3: begin
              if (wait_pend) st <= S_TW;
              else begin
                st <= S_T4;
                if (!is_wr) rdata_q <= ad_i;
              end
            end
            S_TW: begin
              if (rdy_q) begin
                st <= S_T4;
                if (!is_wr) rdata_q <= ad_i;
              end
            end
            S_T4: begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign busy_o   = active;
  assign done_o   = done_q;
  assign rdata_o  = rdata_q;
  assign ale_o    = (st == S_T1) && !ph;
  assign ad_oe_o  = (st == S_T1) || (is_wr && data_win);
  assign ad_o     = (st == S_T1) ? addr_q : ((is_wr && data_win) ? wdata_q : '0);
  assign rd_n_o   = !(!is_wr && strobe_win);
  assign wr_n_o   = !(is_wr && strobe_win);
  assign mreq_n_o = !(!is_io && data_win);
  assign iorq_n_o = !(is_io && data_win);

  always_comb begin
    cs_n_o = '1;
    if (active) cs_n_o[cs_q] = 1'b0;
  end

endmodule

// File: rtl/mux_bus_master_chk.sv
module mux_bus_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy_o,
  input logic           done_o,
  input logic           ad_oe_o,
  input logic           ale_o,
  input logic           rd_n_o,
  input logic           wr_n_o,
  input logic           mreq_n_o,
  input logic           iorq_n_o,
  input logic [NCS-1:0] cs_n_o
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o)); // R5

  AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mreq_n_o && !iorq_n_o)); // R6

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o)); // R3

  AST_ALE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_o) |=> $fell(ale_o)); // R3

  AST_ALE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> busy_o); // R3

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o); // R7

endmodule

bind mux_bus_master mux_bus_master_chk #(.NCS(NCS)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .ad_oe_o(ad_oe_o), .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
  .mreq_n_o(mreq_n_o), .iorq_n_o(iorq_n_o), .cs_n_o(cs_n_o)
);

// File: tb/mux_bus_master_tb_top.sv
module mux_bus_master_tb_top;
  localparam int BW = 16;
  localparam int NCS = 4;
  localparam int CSW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0, req_write_i = 1'b0, req_io_i = 1'b0;
  logic [BW-1:0] req_addr_i = '0, req_wdata_i = '0, ad_i = '0;
  logic [CSW-1:0] req_cs_i = '0;
  logic ready_i = 1'b1;
  logic busy_o, done_o, ad_oe_o, ale_o, rd_n_o, wr_n_o, mreq_n_o, iorq_n_o;
  logic [BW-1:0] rdata_o, ad_o;
  logic [NCS-1:0] cs_n_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mux_bus_master #(.BW(BW), .NCS(NCS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_write_i(req_write_i),
    .req_io_i(req_io_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_cs_i(req_cs_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ale_o(ale_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .mreq_n_o(mreq_n_o),
    .iorq_n_o(iorq_n_o), .cs_n_o(cs_n_o), .ready_i(ready_i)
  );

  task automatic chk(input bit ok, input string tag, input int c,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s clk %0d actual %0h expected %0h", tag, c, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!busy_o && !done_o && !ale_o && !ad_oe_o, "R1 idle flags", 0,
        {busy_o, done_o, ale_o, ad_oe_o}, 0);
    chk(rd_n_o && wr_n_o && mreq_n_o && iorq_n_o, "R1 strobes", 0,
        {rd_n_o, wr_n_o, mreq_n_o, iorq_n_o}, 4'hf);
    chk(cs_n_o == '1, "R1 chip selects", 0, cs_n_o, 4'hf);
  endtask

  // ready_i is low during clocks lo..hi-1 (clock 0 is the request clock).
  // ign_at > 0 raises a second request at that clock, which must be ignored (R2).
  task automatic run_txn(input bit wr, input bit io, input logic [BW-1:0] addr,
                         input logic [BW-1:0] data, input logic [CSW-1:0] cs,
                         input int lo, input int hi, input int exp_w,
                         input int ign_at, input string name);
    int len;
    len = 8 + 2 * exp_w;
    $display("scenario %s", name);
    @(negedge clk);
    req_i = 1'b1; req_write_i = wr; req_io_i = io;
    req_addr_i = addr; req_wdata_i = data; req_cs_i = cs;
    ad_i = wr ? '0 : data;
    ready_i = !(0 >= lo && 0 < hi);
    for (int c = 1; c <= len + 4; c++) begin
      @(negedge clk);
      chk(busy_o == (c <= len), "R7/R8 busy length", c, busy_o, c <= len);
      chk(done_o == (c == len + 1), "R10 done pulse", c, done_o, c == len + 1);
      chk(ale_o == (c == 1), "R3 ale", c, ale_o, c == 1);
      chk(cs_n_o == ((c <= len) ? ~(4'b1 << cs) : 4'hf), "R3 chip select", c,
          cs_n_o, (c <= len) ? ~(4'b1 << cs) : 4'hf);
      if (c <= 2) begin
        chk(ad_oe_o && ad_o == addr, "R3 address phase", c, {ad_oe_o, ad_o}, {1'b1, addr});
      end else if (c <= len) begin
        chk(ad_oe_o == wr, "R4 bus enable", c, ad_oe_o, wr);
        if (wr) chk(ad_o == data, "R4 write data", c, ad_o, data);
      end else begin
        chk(!ad_oe_o, "R4 bus released", c, ad_oe_o, 0);
      end
      chk(rd_n_o == !(!wr && c >= 3 && c <= len - 2), "R5 rd strobe", c,
          rd_n_o, !(!wr && c >= 3 && c <= len - 2));
      chk(wr_n_o == !(wr && c >= 3 && c <= len - 2), "R5 wr strobe", c,
          wr_n_o, !(wr && c >= 3 && c <= len - 2));
      chk(mreq_n_o == !(!io && c >= 3 && c <= len), "R6 mreq", c,
          mreq_n_o, !(!io && c >= 3 && c <= len));
      chk(iorq_n_o == !(io && c >= 3 && c <= len), "R6 iorq", c,
          iorq_n_o, !(io && c >= 3 && c <= len));
      if (!wr && c == len + 1) chk(rdata_o == data, "R10 read data", c, rdata_o, data);
      req_i = (ign_at > 0 && c == ign_at);
      if (req_i) begin
        req_addr_i = ~addr; req_write_i = ~wr;
      end
      ready_i = !(c >= lo && c < hi);
    end
    req_i = 1'b0;
    ready_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    test_reset();
    run_txn(0, 0, 16'h1234, 16'hbeef, 2'd0, 99, 99, 0, 0, "R7 memory read");
    run_txn(1, 0, 16'h4321, 16'ha55a, 2'd1, 99, 99, 0, 0, "R7 memory write");
    run_txn(0, 1, 16'h00f0, 16'h0f0f, 2'd2, 99, 99, 0, 0, "R6 io read");
    run_txn(1, 1, 16'h8001, 16'h7ffe, 2'd3, 99, 99, 0, 0, "R6 io write");
    run_txn(0, 0, 16'h2222, 16'hc3c3, 2'd1, 0, 9, 2, 0, "R8 read two waits");
    run_txn(1, 1, 16'h3333, 16'h5aa5, 2'd2, 0, 12, 4, 0, "R8 write four waits");
    run_txn(0, 0, 16'h4444, 16'h1111, 2'd0, 5, 7, 0, 0, "R9 late ready drop");
    run_txn(1, 0, 16'h5555, 16'h9999, 2'd3, 99, 99, 0, 4, "R2 ignored request");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule